// File: doc/BRIEF.md
# Interval Timer Channel Read Path

This block supplies the CPU read data for one channel of a programmable interval timer. It watches the channel's live 16-bit count, its output pin level and its programmed control fields. On command it freezes two things independently: a status byte that describes the channel, and a snapshot of the count. A CPU read strobe then pulls bytes out one at a time. A pending status byte is always returned first. The frozen count comes next, in the byte format the channel is programmed for. After that, reads see the live count again.

A control-word rewrite discards anything still pending and resets the byte order to the low byte. The block also keeps a flag for a freshly written count that the counting element has not yet taken in. That flag appears in the status byte. The counting element, the output waveform logic and address decoding sit outside this block.

Top module: `tmr_rd_path`

## Requirements
- R1: After reset nothing is frozen, no status byte is pending, the byte pointer is at the low byte and the null-count flag is clear. A read in two-byte format returns the live count's low byte.
- R2: The status byte is laid out as follows: bit 7 is the output pin level, bit 6 the null-count flag, bits 5:4 the format field `rwFmt`, bits 3:1 `modeSel` and bit 0 `bcdSel`. All of these are sampled in the cycle the status latch command is taken.
- R3: A status byte is captured only on `latchStatus`. A second `latchStatus` while a status byte is still unread has no effect.
- R4: `latchCount` captures the live count. Reads of the count return that snapshot even if the live count changes afterwards.
- R5: A `latchCount` that arrives while a frozen count has not been fully read has no effect.
- R6: When a status byte is pending, the next read returns it, whichever of the status and count latches came first. The count follows on the subsequent reads.
- R7: With `rwFmt` = 2'b11 (two-byte format), reads alternate low byte then high byte, for frozen and live counts alike. A frozen count is released after its high byte is read, and later reads show the live count.
- R8: With `rwFmt` = 2'b01, reads return only the low byte. With 2'b10, reads return only the high byte. In both cases a single read releases a frozen count.
- R9: A `ctrlWrite` pulse releases a frozen count, discards a pending status byte and returns the byte pointer to the low byte.
- R10: The null-count flag sets on `countWrite` and clears on `loadDone`. If both arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| liveCount | input | 16 | Current value of the counting element |
| outLevel | input | 1 | Current level of the channel output pin |
| rwFmt | input | 2 | Programmed byte format: 01 low only, 10 high only, 11 low then high |
| modeSel | input | 3 | Programmed operating mode |
| bcdSel | input | 1 | Programmed BCD counting select |
| ctrlWrite | input | 1 | Pulse: control word rewritten |
| countWrite | input | 1 | Pulse: new count value written |
| loadDone | input | 1 | Pulse: counting element loaded the written count |
| latchCount | input | 1 | Pulse: freeze the count |
| latchStatus | input | 1 | Pulse: freeze the status byte |
| readStb | input | 1 | Pulse: CPU consumes the byte on rdData |
| rdData | output | 8 | Byte presented for the CPU read |

## Verification
The assertions check the following on every cycle:
- a pending status byte survives until a read or a reprogram;
- a frozen count stays frozen and its snapshot does not move;
- the pointer toggles on two-byte reads;
- a reprogram clears all pending state;
- the null-count flag responds to writes and loads.

Only the bench scenarios can show the byte-level read order: status before count regardless of latch order, the handover from snapshot back to the live count, and the bit layout of the status byte.

// File: rtl/tmr_rd_pkg.sv
package tmr_rd_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  localparam logic [1:0] FMT_LSB  = 2'b01;
  localparam logic [1:0] FMT_MSB  = 2'b10;
  localparam logic [1:0] FMT_BOTH = 2'b11;

  typedef struct packed {
    logic capStatus;
    logic capCount;
    logic showStatus;
    logic useLatch;
    logic selMsb;
  } rd_strobe_t;
endpackage

// File: rtl/tmr_rd_ctrl.sv
module tmr_rd_ctrl
  import tmr_rd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] rwFmt,
  input  logic       ctrlWrite,
  input  logic       latchCount,
  input  logic       latchStatus,
  input  logic       readStb,
  output rd_strobe_t strb
);
  logic statusValid, countLatched, bytePtr;
  logic readCount, finalByte, twoByte;

  always_comb begin
    twoByte         = (rwFmt == FMT_BOTH);
    readCount       = readStb && !statusValid;
    finalByte       = readCount && (!twoByte || bytePtr);
    strb.capStatus  = latchStatus && !statusValid && !ctrlWrite;
    strb.capCount   = latchCount && !countLatched && !ctrlWrite;
    strb.showStatus = statusValid;
    strb.useLatch   = countLatched;
    strb.selMsb     = (rwFmt == FMT_MSB) || (twoByte && bytePtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrlWrite) begin
      statusValid  <= 1'b0;
      countLatched <= 1'b0;
      bytePtr      <= 1'b0;
    end else begin
      statusValid  <= strb.capStatus || (statusValid && !readStb);
      countLatched <= strb.capCount || (countLatched && !finalByte);
      if (readCount && twoByte) bytePtr <= ~bytePtr;
    end
  end

  // R9: reprogram clears all pending read state
  p_reprogram_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite |=> (!strb.showStatus && !strb.useLatch && !bytePtr));

  // R3: status byte persists until read or reprogram
  p_status_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && !readStb && !ctrlWrite) |=> statusValid);

  // R6: the read that sees a pending status byte consumes it
  p_status_consumed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && readStb) |=> !strb.showStatus);

  // R5: frozen count survives further latch commands until read out
  p_latch_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    (countLatched && !readStb && !ctrlWrite) |=> countLatched);

  // R7: two-byte reads flip the byte pointer
  p_ptr_toggle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (twoByte && readStb && !statusValid && !ctrlWrite) |=> (bytePtr != $past(bytePtr)));
endmodule

// File: rtl/tmr_rd_dpath.sv
module tmr_rd_dpath
  import tmr_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rd_strobe_t        strb,
  input  logic [CNT_W-1:0]  liveCount,
  input  logic              outLevel,
  input  logic [1:0]        rwFmt,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              bcdSel,
  input  logic              countWrite,
  input  logic              loadDone,
  output logic [BYTE_W-1:0] rdData
);
  logic [CNT_W-1:0]  cntLatch;
  logic [BYTE_W-1:0] statusReg;
  logic              nullFlag;
  logic [CNT_W-1:0]  countSrc;
  logic [BYTE_W-1:0] countByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntLatch  <= '0;
      statusReg <= '0;
      nullFlag  <= 1'b0;
    end else begin
      if (strb.capCount)  cntLatch  <= liveCount;
      if (strb.capStatus) statusReg <= {outLevel, nullFlag, rwFmt, modeSel, bcdSel};
      if (countWrite)     nullFlag  <= 1'b1;
      else if (loadDone)  nullFlag  <= 1'b0;
    end
  end

  always_comb begin
    countSrc  = strb.useLatch ? cntLatch : liveCount;
    countByte = strb.selMsb ? countSrc[CNT_W-1:BYTE_W] : countSrc[BYTE_W-1:0];
    rdData    = strb.showStatus ? statusReg : countByte;
  end

  // R4: snapshot does not move while it is in use
  p_snapshot_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.useLatch |=> $stable(cntLatch));

  // R2: status bit 7 carries the pin level from the capture cycle
  p_status_pin_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capStatus |=> (statusReg[7] == $past(outLevel)));

  // R10: a count write sets the null flag
  p_null_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    countWrite |=> nullFlag);

  // R10: a load without a new write clears it
  p_null_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (loadDone && !countWrite) |=> !nullFlag);
endmodule

// File: rtl/tmr_rd_path.sv
module tmr_rd_path
  import tmr_rd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] liveCount,
  input  logic        outLevel,
  input  logic [1:0]  rwFmt,
  input  logic [2:0]  modeSel,
  input  logic        bcdSel,
  input  logic        ctrlWrite,
  input  logic        countWrite,
  input  logic        loadDone,
  input  logic        latchCount,
  input  logic        latchStatus,
  input  logic        readStb,
  output logic [7:0]  rdData
);
  rd_strobe_t strb;

  tmr_rd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rwFmt(rwFmt), .ctrlWrite(ctrlWrite),
    .latchCount(latchCount), .latchStatus(latchStatus), .readStb(readStb),
    .strb(strb)
  );

  tmr_rd_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .liveCount(liveCount),
    .outLevel(outLevel), .rwFmt(rwFmt), .modeSel(modeSel), .bcdSel(bcdSel),
    .countWrite(countWrite), .loadDone(loadDone), .rdData(rdData)
  );
endmodule

// File: tb/tmr_rd_path_test.sv
module tmr_rd_path_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] liveCount = 16'hA1B2;
  logic        outLevel = 1'b0;
  logic [1:0]  rwFmt = 2'b11;
  logic [2:0]  modeSel = 3'b000;
  logic        bcdSel = 1'b0;
  logic        ctrlWrite = 1'b0, countWrite = 1'b0, loadDone = 1'b0;
  logic        latchCount = 1'b0, latchStatus = 1'b0, readStb = 1'b0;
  logic [7:0]  rdData;
  int          total = 0;
  int          failCnt = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tmr_rd_path uut (
    .clk(clk), .rstN(rstN), .liveCount(liveCount), .outLevel(outLevel),
    .rwFmt(rwFmt), .modeSel(modeSel), .bcdSel(bcdSel), .ctrlWrite(ctrlWrite),
    .countWrite(countWrite), .loadDone(loadDone), .latchCount(latchCount),
    .latchStatus(latchStatus), .readStb(readStb), .rdData(rdData)
  );

  // {1'b0, out, fmt[1:0], mode[2:0], bcd, expected status[7:0]}
  localparam logic [15:0] VEC [6] = '{
    16'h74B4, 16'h1111, 16'h6BAB, 16'h3E3E, 16'h4787, 16'h2828
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // 0 ctrlWrite, 1 countWrite, 2 loadDone, 3 latchCount, 4 latchStatus, 5 count+load
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: ctrlWrite = 1'b1;
      1: countWrite = 1'b1;
      2: loadDone = 1'b1;
      3: latchCount = 1'b1;
      4: latchStatus = 1'b1;
      default: begin countWrite = 1'b1; loadDone = 1'b1; end
    endcase
    @(negedge clk);
    {ctrlWrite, countWrite, loadDone, latchCount, latchStatus} = '0;
  endtask

  task automatic doRead(input string req, input logic [7:0] exp);
    @(negedge clk);
    check(req, rdData, exp);
    readStb = 1'b1;
    @(negedge clk);
    readStb = 1'b0;
  endtask

  task automatic setFmt(input logic [1:0] f);
    rwFmt = f;
    strobe(0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset live low byte", rdData, 8'hB2);

    // R2 status layout table
    for (int i = 0; i < 6; i++) begin
      outLevel = VEC[i][14];
      rwFmt    = VEC[i][13:12];
      modeSel  = VEC[i][11:9];
      bcdSel   = VEC[i][8];
      strobe(4);
      doRead("R2 status layout", VEC[i][7:0]);
    end

    // R7 unlatched two-byte reads
    modeSel = 3'b010; bcdSel = 1'b0; outLevel = 1'b0;
    setFmt(2'b11);
    liveCount = 16'hA1B2;
    doRead("R7 live low", 8'hB2);
    doRead("R7 live high", 8'hA1);

    // R4 / R5 snapshot and repeat latch
    liveCount = 16'h1234;
    strobe(3);
    liveCount = 16'h5678;
    doRead("R4 snapshot low", 8'h34);
    liveCount = 16'h9ABC;
    strobe(3);
    doRead("R5 repeat latch ignored", 8'h12);
    doRead("R7 released low", 8'hBC);
    doRead("R7 released high", 8'h9A);

    // R6 count latched first, then status; R3 second status ignored
    outLevel = 1'b1;
    strobe(3);
    strobe(4);
    outLevel = 1'b0;
    strobe(4);
    doRead("R6 status first / R3", 8'hB4);
    doRead("R6 count low", 8'hBC);
    doRead("R6 count high", 8'h9A);

    // R6 status latched first, then count
    strobe(4);
    liveCount = 16'h2468;
    strobe(3);
    liveCount = 16'h0000;
    doRead("R6 swapped status", 8'h34);
    doRead("R6 swapped low", 8'h68);
    doRead("R6 swapped high", 8'h24);

    // R8 single-byte formats
    setFmt(2'b01);
    liveCount = 16'h4321;
    strobe(3);
    liveCount = 16'h1111;
    doRead("R8 low only snapshot", 8'h21);
    doRead("R8 low only released", 8'h11);
    setFmt(2'b10);
    liveCount = 16'h8765;
    strobe(3);
    liveCount = 16'h2222;
    doRead("R8 high only snapshot", 8'h87);
    doRead("R8 high only released", 8'h22);

    // R9 reprogram releases everything
    setFmt(2'b11);
    liveCount = 16'hCAFE;
    strobe(3);
    strobe(4);
    liveCount = 16'hBEEF;
    setFmt(2'b11);
    doRead("R9 discard status and latch", 8'hEF);
    setFmt(2'b11);
    doRead("R9 pointer reset", 8'hEF);

    // R10 null-count flag
    strobe(1);
    strobe(4);
    doRead("R10 null set", 8'h74);
    strobe(2);
    strobe(4);
    doRead("R10 null cleared", 8'h34);
    strobe(5);
    strobe(4);
    doRead("R10 write wins tie", 8'h74);
    strobe(2);
    strobe(4);
    doRead("R10 cleared again", 8'h34);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failCnt, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - failCnt, total);
      $finish;
    end
  end
endmodule